// File: doc/BRIEF.md
# Translation Lookaside Cache with Walker Port and Flush

This block keeps a small, fully associative set of recent address translations in front of a page-table walker. A request presents a virtual address and its access kind (a write flag and a user-mode flag). The upper bits of that address, the virtual page number, form the lookup key. On a hit the block checks the stored permissions. In the same cycle it returns either the physical address, formed from the stored frame number and the untouched page offset, or a fault.

On a miss the block raises a request to the external walker and holds the requester stalled until the walker answers. A good answer is installed and the held request then completes through the normal hit path on the following cycle. A bad answer completes the request with a fault. Entries carry no address-space tag, so software switches context by writing the root register, which drops every entry. A separate command drops only the entry whose page matches a given address.

Any maintenance that lands while a walk is in flight causes that walk's answer to be thrown away, so a stale translation is never installed. The requester then simply misses again and a fresh walk starts.

Top module: `xlt_cache`

## Requirements
- R1: After reset every entry is invalid, `walk_req` and `rsp_done` are low, and the first lookup of any address reports `lookup_miss`.
- R2: A lookup that hits, with its access allowed, raises `lookup_hit` and `rsp_done` in the same cycle with `rsp_fault` low and `rsp_paddr` equal to the stored 20-bit frame number followed by address bits [11:0].
- R3: Each entry holds two permission bits, writable and user-accessible; a hit by a write to a non-writable page, or by a user-mode access to a non-user page, raises `rsp_done` and `rsp_fault` in the same cycle and starts no walk.
- R4: A lookup that misses raises `lookup_miss`; on the next cycle `walk_req` is high with `walk_vpn` equal to address bits [31:12], and both hold until the cycle in which `walk_done` is high.
- R5: A `walk_done` with `walk_ok` high installs the returned frame number and permissions, and the still-held request hits on the following cycle, with the R3 permission check applied.
- R6: A `walk_done` with `walk_ok` low raises `rsp_done` and `rsp_fault` in that same cycle and installs nothing, so a later lookup of that page misses again.
- R7: While `walk_req` is high, `lookup_hit` and `lookup_miss` stay low, and `rsp_done` rises only as in R6; `lookup_hit` and `lookup_miss` are never high together.
- R8: A cycle with `root_wr` high invalidates every entry, so no lookup hits on the next cycle.
- R9: A cycle with `inv_valid` high invalidates only the entry whose page equals `inv_vaddr` bits [31:12]; every other entry still hits.
- R10: If `root_wr` or `inv_valid` is high in the cycle a walk is launched, or in any cycle while it is in flight, that walk's answer is discarded: no install and no `rsp_done`, and the held request misses again on the next cycle.
- R11: An install goes to the lowest-numbered invalid entry. When all 16 entries are valid, it goes to the entry named by a replacement pointer that is 0 after reset, advances by one after each such replacement, and wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present; held until `rsp_done` |
| req_vaddr | input | 32 | Virtual address of the request |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request is made in user mode |
| lookup_hit | output | 1 | Lookup found a valid matching entry |
| lookup_miss | output | 1 | Lookup found no matching entry |
| rsp_done | output | 1 | Request completes this cycle |
| rsp_fault | output | 1 | Completion is a page fault |
| rsp_paddr | output | 32 | Translated physical address |
| walk_req | output | 1 | Walk outstanding |
| walk_vpn | output | 20 | Page number to walk |
| walk_done | input | 1 | Walker answer present |
| walk_ok | input | 1 | Walker found a valid mapping |
| walk_pfn | input | 20 | Frame number from the walker |
| walk_wr_ok | input | 1 | Walked page is writable |
| walk_usr_ok | input | 1 | Walked page is user-accessible |
| root_wr | input | 1 | Root register write strobe; flushes all entries |
| inv_valid | input | 1 | Single-page invalidate strobe |
| inv_vaddr | input | 32 | Address whose page is invalidated |

## Verification
A wrong valid bit shows at the very next lookup of that page: `lookup_hit` appears where `lookup_miss` belongs, or the reverse, within one cycle of presenting the address. A corrupted frame or permission field surfaces in the same cycle as a wrong `rsp_paddr` or a wrong `rsp_fault`. A bad replacement pointer stays hidden until the table is full and a later install evicts the wrong page, which a subsequent probe then exposes. For that reason the eviction order is driven directly from reset. A walk result installed after a flush or invalidate shows as a hit on the retried request, where a repeated miss is expected.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int PERM_W   = 2;
  localparam int PERM_WR  = 0;
  localparam int PERM_USR = 1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } xlt_state_e;
endpackage

// File: rtl/xlt_match.sv
module xlt_match #(
  parameter int N  = 16,
  parameter int KW = 20
) (
  input  logic [N-1:0]    valid,
  input  logic [N*KW-1:0] keys_flat,
  input  logic [KW-1:0]   key,
  output logic [N-1:0]    hit_vec
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = valid[i] && (keys_flat[i*KW +: KW] == key);
  end
endmodule

// File: rtl/xlt_victim.sv
module xlt_victim #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  valid,
  input  logic [IW-1:0] rr_ptr,
  output logic [IW-1:0] idx,
  output logic          use_rr
);
  always_comb begin
    idx    = rr_ptr;
    use_rr = 1'b1;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        idx    = IW'(i);
        use_rr = 1'b0;
      end
    end
  end
endmodule

// File: rtl/xlt_cache.sv
module xlt_cache #(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int PG_W = 12,
  parameter int N    = 16,
  localparam int VPN_W = VA_W - PG_W,
  localparam int PFN_W = PA_W - PG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  output logic             lookup_hit,
  output logic             lookup_miss,
  output logic             rsp_done,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             walk_done,
  input  logic             walk_ok,
  input  logic [PFN_W-1:0] walk_pfn,
  input  logic             walk_wr_ok,
  input  logic             walk_usr_ok,
  input  logic             root_wr,
  input  logic             inv_valid,
  input  logic [VA_W-1:0]  inv_vaddr
);
  import xlt_pkg::*;

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  xlt_state_e               st_q;
  logic [N-1:0]             vld_q, vld_d;
  logic [VPN_W-1:0]         tag_q  [N];
  logic [PFN_W-1:0]         pfn_q  [N];
  logic [PERM_W-1:0]        perm_q [N];
  logic [IW-1:0]            rr_q;
  logic                     drop_q;
  logic [VPN_W-1:0]         walk_vpn_q;

  logic [N*VPN_W-1:0]       tags_flat;
  logic [N-1:0]             look_vec, inv_vec;
  logic [VPN_W-1:0]         look_key, inv_key;
  logic [PFN_W-1:0]         hit_pfn;
  logic [PERM_W-1:0]        hit_perm;
  logic                     any_hit, perm_bad, maint, do_fill, walk_fail;
  logic [IW-1:0]            vic_idx;
  logic                     vic_rr;

  assign look_key = req_vaddr[VA_W-1:PG_W];
  assign inv_key  = inv_vaddr[VA_W-1:PG_W];
  assign maint    = root_wr | inv_valid;

  for (genvar i = 0; i < N; i++) begin : g_flat
    assign tags_flat[i*VPN_W +: VPN_W] = tag_q[i];
  end

  xlt_match #(.N(N), .KW(VPN_W)) u_look (
    .valid(vld_q), .keys_flat(tags_flat), .key(look_key), .hit_vec(look_vec)
  );

  xlt_match #(.N(N), .KW(VPN_W)) u_inv (
    .valid(vld_q), .keys_flat(tags_flat), .key(inv_key), .hit_vec(inv_vec)
  );

  xlt_victim #(.N(N), .IW(IW)) u_vic (
    .valid(vld_q), .rr_ptr(rr_q), .idx(vic_idx), .use_rr(vic_rr)
  );

  // Entries are unique per page, so an OR of the selected fields is the read mux.
  always_comb begin
    hit_pfn  = '0;
    hit_perm = '0;
    for (int i = 0; i < N; i++) begin
      if (look_vec[i]) begin
        hit_pfn  = hit_pfn | pfn_q[i];
        hit_perm = hit_perm | perm_q[i];
      end
    end
  end

  assign any_hit  = |look_vec;
  assign perm_bad = (req_write && !hit_perm[PERM_WR]) || (req_user && !hit_perm[PERM_USR]);

  assign lookup_hit  = (st_q == ST_IDLE) && req_valid && any_hit;
  assign lookup_miss = (st_q == ST_IDLE) && req_valid && !any_hit;

  assign walk_fail = (st_q == ST_WALK) && walk_done && !walk_ok && !drop_q && !maint;
  assign do_fill   = (st_q == ST_WALK) && walk_done && walk_ok && !drop_q && !maint;

  assign rsp_done  = lookup_hit || walk_fail;
  assign rsp_fault = (lookup_hit && perm_bad) || walk_fail;
  assign rsp_paddr = {hit_pfn, req_vaddr[PG_W-1:0]};

  assign walk_req = (st_q == ST_WALK);
  assign walk_vpn = walk_vpn_q;

  always_comb begin
    vld_d = vld_q;
    if (do_fill) vld_d[vic_idx] = 1'b1;
    if (root_wr)        vld_d = '0;
    else if (inv_valid) vld_d = vld_d & ~inv_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      vld_q      <= '0;
      rr_q       <= '0;
      drop_q     <= 1'b0;
      walk_vpn_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (do_fill && vic_rr) begin
        rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
      end
      case (st_q)
        ST_IDLE: begin
          if (lookup_miss) begin
            st_q       <= ST_WALK;
            walk_vpn_q <= look_key;
            drop_q     <= maint;
          end
        end
        default: begin
          if (walk_done) begin
            st_q   <= ST_IDLE;
            drop_q <= 1'b0;
          end else if (maint) begin
            drop_q <= 1'b1;
          end
        end
      endcase
    end
  end

  // Payload storage: no reset, single write port, validity tracked separately.
  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[vic_idx]  <= walk_vpn_q;
      pfn_q[vic_idx]  <= walk_pfn;
      perm_q[vic_idx] <= {walk_usr_ok, walk_wr_ok};
    end
  end
endmodule

// File: rtl/xlt_cache_chk.sv
module xlt_cache_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int PG_W = 12,
  parameter int N    = 16,
  localparam int VPN_W = VA_W - PG_W,
  localparam int PFN_W = PA_W - PG_W
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             req_write,
  input logic             req_user,
  input logic             lookup_hit,
  input logic             lookup_miss,
  input logic             rsp_done,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             walk_req,
  input logic [VPN_W-1:0] walk_vpn,
  input logic             walk_done,
  input logic             walk_ok,
  input logic [PFN_W-1:0] walk_pfn,
  input logic             walk_wr_ok,
  input logic             walk_usr_ok,
  input logic             root_wr,
  input logic             inv_valid,
  input logic [VA_W-1:0]  inv_vaddr
);
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(lookup_hit && lookup_miss)); // R7

  AST_STALL_IN_WALK: assert property (@(posedge clk) disable iff (rst)
    walk_req |-> (!lookup_hit && !lookup_miss)); // R7

  AST_MISS_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    lookup_miss |=> (walk_req && walk_vpn == $past(req_vaddr[VA_W-1:PG_W]))); // R4

  AST_WALK_HELD: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !walk_done) |=> (walk_req && $stable(walk_vpn))); // R4

  AST_WALK_ENDS: assert property (@(posedge clk) disable iff (rst)
    (walk_req && walk_done) |=> !walk_req); // R5

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    root_wr |=> !lookup_hit); // R8

  AST_FAULT_DONE: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_done); // R3

  AST_HIT_DONE: assert property (@(posedge clk) disable iff (rst)
    lookup_hit |-> rsp_done); // R2
endmodule

bind xlt_cache xlt_cache_chk #(.VA_W(VA_W), .PA_W(PA_W), .PG_W(PG_W), .N(N)) u_chk (.*);

// File: tb/xlt_cache_test.sv
`timescale 1ns/1ps
module xlt_cache_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        lookup_hit, lookup_miss, rsp_done, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic        walk_done = 1'b0, walk_ok = 1'b0, walk_wr_ok = 1'b0, walk_usr_ok = 1'b0;
  logic [19:0] walk_pfn = '0;
  logic        root_wr = 1'b0, inv_valid = 1'b0;
  logic [31:0] inv_vaddr = '0;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xlt_cache uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .lookup_hit(lookup_hit), .lookup_miss(lookup_miss), .rsp_done(rsp_done),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_done(walk_done), .walk_ok(walk_ok),
    .walk_pfn(walk_pfn), .walk_wr_ok(walk_wr_ok), .walk_usr_ok(walk_usr_ok),
    .root_wr(root_wr), .inv_valid(inv_valid), .inv_vaddr(inv_vaddr)
  );

  // Reference model of the table
  bit        mv  [16];
  bit [19:0] mtag[16];
  bit [19:0] mpfn[16];
  bit        mw  [16];
  bit        mu  [16];
  int        mrr = 0;

  // Page table seen by the walker
  function automatic bit pt_ok(input bit [19:0] v);   return v[3:0] != 4'hF; endfunction
  function automatic bit [19:0] pt_pfn(input bit [19:0] v); return v ^ 20'h5A5A5; endfunction

  function automatic bit [31:0] mkva(input bit [19:0] v, input bit [11:0] off);
    return {v, off};
  endfunction

  function automatic int m_find(input bit [19:0] v);
    for (int i = 0; i < 16; i++) if (mv[i] && mtag[i] == v) return i;
    return -1;
  endfunction

  function automatic void m_install(input bit [19:0] v);
    int idx = -1;
    for (int i = 15; i >= 0; i--) if (!mv[i]) idx = i;
    if (idx < 0) begin
      idx = mrr;
      mrr = (mrr + 1) % 16;
    end
    mv[idx] = 1; mtag[idx] = v; mpfn[idx] = pt_pfn(v); mw[idx] = v[4]; mu[idx] = v[5];
  endfunction

  function automatic void m_inval(input bit [19:0] v);
    for (int i = 0; i < 16; i++) if (mv[i] && mtag[i] == v) mv[i] = 0;
  endfunction

  function automatic void m_flush();
    for (int i = 0; i < 16; i++) mv[i] = 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic probe(input bit [31:0] va, input bit exp, input string req);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = 0; req_user = 0;
    #1;
    chk(lookup_hit == exp && lookup_miss == !exp, req, "probe hit", lookup_hit, exp);
    #1 req_valid = 0;
  endtask

  task automatic inval(input bit [31:0] va);
    @(negedge clk);
    inv_valid = 1; inv_vaddr = va;
    @(posedge clk);
    m_inval(va[31:12]);
    @(negedge clk);
    inv_valid = 0;
  endtask

  task automatic flush();
    @(negedge clk);
    root_wr = 1;
    @(posedge clk);
    m_flush();
    @(negedge clk);
    root_wr = 0;
  endtask

  task automatic access(input bit [31:0] va, input bit wr, input bit us,
                        input bit inj, input bit [31:0] inj_va);
    bit [19:0] v = va[31:12];
    bit fin = 0, walked = 0, first = 1, disc, bad;
    int guard = 0, idx, d;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = wr; req_user = us;
    while (!fin && guard < 6) begin
      guard++;
      #1;
      idx = m_find(v);
      if (idx >= 0) begin
        bad = (wr && !mw[idx]) || (us && !mu[idx]);
        chk(lookup_hit && !lookup_miss, walked ? "R5" : "R2", "hit", lookup_hit, 1);
        chk(rsp_done && rsp_fault == bad, bad ? "R3" : "R2", "fault", rsp_fault, bad);
        if (!bad) chk(rsp_paddr == {mpfn[idx], va[11:0]}, "R2", "paddr",
                      rsp_paddr, {mpfn[idx], va[11:0]});
        fin = 1;
        @(posedge clk);
        @(negedge clk);
      end else begin
        chk(lookup_miss && !lookup_hit && !rsp_done, "R4", "miss", lookup_miss, 1);
        disc = 0;
        @(negedge clk); #1;
        chk(walk_req && walk_vpn == v, "R4", "walk vpn", walk_vpn, v);
        chk(!lookup_hit && !lookup_miss && !rsp_done, "R7", "stall", {lookup_hit, lookup_miss, rsp_done}, 0);
        if (inj && first) begin
          inv_valid = 1; inv_vaddr = inj_va; disc = 1;
          @(posedge clk);
          m_inval(inj_va[31:12]);
        end
        first = 0;
        d = $urandom_range(0, 3);
        for (int k = 0; k < d; k++) begin
          @(negedge clk); inv_valid = 0; #1;
          chk(walk_req && !rsp_done, "R4", "walk held", walk_req, 1);
        end
        @(negedge clk);
        inv_valid = 0;
        walk_done = 1; walk_ok = pt_ok(v); walk_pfn = pt_pfn(v);
        walk_wr_ok = v[4]; walk_usr_ok = v[5];
        #1;
        if (disc) begin
          chk(!rsp_done, "R10", "dropped walk done", rsp_done, 0);
        end else if (!pt_ok(v)) begin
          chk(rsp_done && rsp_fault, "R6", "walk fault", {rsp_done, rsp_fault}, 2'b11);
          fin = 1;
        end else begin
          chk(!rsp_done, "R7", "no done on fill", rsp_done, 0);
        end
        @(posedge clk);
        if (!disc && pt_ok(v)) begin
          m_install(v);
          walked = 1;
        end
        @(negedge clk);
        walk_done = 0;
        if (disc) begin
          #1;
          chk(lookup_miss, "R10", "retry misses", lookup_miss, 1);
          #1;
        end
      end
    end
    if (!fin) chk(0, "R5", "access incomplete", 0, 1);
    req_valid = 0;
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) mv[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(!walk_req && !rsp_done, "R1", "reset idle", {walk_req, rsp_done}, 0);
    rst = 0;
    probe(mkva(20'h00100, 12'h0), 0, "R1");

    // Fill from reset: entries 0..15 in order
    for (int i = 0; i < 16; i++) access(mkva(20'h00100 + 20'(i * 16), 12'h004), 0, 0, 0, 0);
    probe(mkva(20'h001F0, 12'h0), 1, "R11");
    access(mkva(20'h00200, 12'h0), 0, 0, 0, 0);
    probe(mkva(20'h00100, 12'h0), 0, "R11");
    probe(mkva(20'h00110, 12'h0), 1, "R11");
    access(mkva(20'h00210, 12'h0), 0, 0, 0, 0);
    probe(mkva(20'h00110, 12'h0), 0, "R11");
    probe(mkva(20'h00120, 12'h0), 1, "R11");

    inval(mkva(20'h00150, 12'h0));
    probe(mkva(20'h00150, 12'h0), 0, "R9");
    probe(mkva(20'h00140, 12'h0), 1, "R9");
    probe(mkva(20'h00160, 12'h0), 1, "R9");
    access(mkva(20'h00220, 12'h0), 0, 0, 0, 0);
    probe(mkva(20'h00120, 12'h0), 1, "R11");
    probe(mkva(20'h00220, 12'h0), 1, "R11");

    access(mkva(20'h00120, 12'hABC), 1, 0, 0, 0);   // R3: write to read-only page
    access(mkva(20'h00140, 12'h123), 0, 1, 0, 0);   // R3: user access to supervisor page
    access(mkva(20'h00130, 12'h777), 1, 1, 0, 0);   // R2: allowed
    access(mkva(20'h0040F, 12'h0), 0, 0, 0, 0);     // R6: walk fails
    probe(mkva(20'h0040F, 12'h0), 0, "R6");

    access(mkva(20'h00300, 12'h010), 0, 0, 1, mkva(20'h00130, 12'h0)); // R10
    probe(mkva(20'h00130, 12'h0), 0, "R10");
    probe(mkva(20'h00300, 12'h0), 1, "R10");

    flush();
    probe(mkva(20'h00120, 12'h0), 0, "R8");
    probe(mkva(20'h00300, 12'h0), 0, "R8");

    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 99);
      bit [19:0] v = 20'h00400 + 20'($urandom_range(0, 47));
      bit [11:0] off = 12'($urandom);
      if (op < 8) inval(mkva(v, off));
      else if (op < 11) flush();
      else access(mkva(v, off), 1'($urandom), 1'($urandom), ($urandom_range(0, 9) == 0),
                  mkva(20'h00400 + 20'($urandom_range(0, 47)), 12'h0));
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule